// File: doc/BRIEF.md
# Sticky Dual-Channel Limit Alert Register

This block records limit violations for two measurement channels. Each channel has one flag for a low-limit violation and one for a high-limit violation. The limit comparators outside the block raise a strobe for one clock when a conversion breaks a limit. The matching flag then latches and stays set until software clears it. A flag that has been read but not cleared reads as set again on every later read.

Software reads the four flags through a read port at the status address, and the unused upper bits read as zero. Software clears flags in three ways:
- A write to the status address clears each flag whose data bit is 1.
- A write of all ones to the status address clears every flag.
- A clear-all strobe from the configuration register clears every flag.

When a violation strobe and a clear of the same flag arrive in the same cycle, the violation wins, so no event is lost. A combined alert output is high whenever any flag is set.

Each flag is a small two-state machine, `alert_flag_cell`:
- The states are `FLAG_IDLE` and `FLAG_LATCHED`.
- The transition `RAISE` goes from `FLAG_IDLE` to `FLAG_LATCHED` on a violation strobe.
- The transition `RELEASE` goes from `FLAG_LATCHED` to `FLAG_IDLE` on a clear with no strobe in the same cycle.
- Every other case holds the state. This includes `HOLD_IDLE`, `HOLD_LATCHED` and the set-beats-clear case `REARM`.

Top module: `limit_alert_reg`

## Requirements
- R1: After reset, all four flags are 0, `rd_data_o` reads 0 at the status address, and `alert_o` is 0.
- R2: Bit positions are fixed: bit 0 is channel 1 low (`viol_lo_i[0]`), bit 1 is channel 1 high (`viol_hi_i[0]`), bit 2 is channel 2 low (`viol_lo_i[1]`) and bit 3 is channel 2 high (`viol_hi_i[1]`). A strobe that is high at a rising clock edge sets its flag, and the flag reads 1 after that edge.
- R3: Bits 7 to 4 of `rd_data_o` always read 0.
- R4: A set flag stays set when no clear reaches it. A violation on another bit or channel sets that bit as well, and the flags already set are kept.
- R5: A write (`wr_en_i` = 1) to the status address (`wr_addr_i` = 4'h4) clears exactly the flags whose bit in `wr_data_i[3:0]` is 1, unless the data is all ones. The other flags keep their value.
- R6: A write of 8'hFF to the status address clears all flags.
- R7: A one-cycle `cfg_clear_i` pulse clears all flags.
- R8: If a flag's violation strobe and a clear of that flag (of any kind) occur in the same cycle, the flag is 1 afterwards.
- R9: `alert_o` is 1 exactly when at least one flag is 1.
- R10: A write to any address other than 4'h4 leaves the flags unchanged. A write to 4'h4 whose low four bits are zero (for example 8'h00 or 8'hF0) also leaves them unchanged.
- R11: A read at any address other than 4'h4 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| viol_lo_i | input | 2 | Low-limit violation strobes, one per channel |
| viol_hi_i | input | 2 | High-limit violation strobes, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| cfg_clear_i | input | 1 | Clear-all command from the configuration register |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 8 | Read data, flags in bits 3 to 0 |
| alert_o | output | 1 | OR of all flags |

## Verification
The flags are exercised with several input patterns, and each pattern exposes a different kind of fault:
- Single strobes on each of the four sources show whether the bit mapping is swapped.
- Strobes that build up across both channels show whether any flag is lost.
- Single-bit and two-bit clear writes show whether a clear leaks into neighbouring flags.
- The all-ones write and the configuration strobe are applied against a full register, to show whether either global clear leaves a flag behind.
- Strobes applied in the same cycle as each kind of clear separate a design where the set wins from one where the clear wins.
- A write of 8'hF0 shows whether the clear-all detection looks at more than the low nibble.
- Writes and reads at a foreign address show whether address decoding is missing.

// File: rtl/limit_alert_pkg.sv
package limit_alert_pkg;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_LATCHED = 1'b1
    } flag_state_e;

endpackage

// File: rtl/alert_flag_cell.sv
module alert_flag_cell
    import limit_alert_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_e state_q;
    flag_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: RAISE, RELEASE, HOLD_IDLE, HOLD_LATCHED, REARM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (set_i) begin
                    state_d = FLAG_LATCHED;
                end
            end
            FLAG_LATCHED: begin
                if (clr_i && !set_i) begin
                    state_d = FLAG_IDLE;
                end
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        flag_o = 1'b0;
        unique case (state_q)
            FLAG_IDLE:    flag_o = 1'b0;
            FLAG_LATCHED: flag_o = 1'b1;
            default:      flag_o = 1'b0;
        endcase
    end

    assert_set_latches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    assert_clear_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));

endmodule

// File: rtl/alert_clear_decode.sv
module alert_clear_decode #(
    parameter int          NFLAG       = 4,
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'h4
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              cfg_clear_i,
    output logic [NFLAG-1:0]  clr_mask_o
);

    logic hit;
    logic all_ones;

    always_comb begin
        hit      = wr_en_i && (wr_addr_i == STATUS_ADDR);
        all_ones = (wr_data_i == {DATA_W{1'b1}});
        if (cfg_clear_i || (hit && all_ones)) begin
            clr_mask_o = {NFLAG{1'b1}};
        end else if (hit) begin
            clr_mask_o = wr_data_i[NFLAG-1:0];
        end else begin
            clr_mask_o = '0;
        end
    end

    always_comb begin
        assert_cfg_clears_all_R7: assert (!cfg_clear_i || (clr_mask_o == {NFLAG{1'b1}}));
        assert_foreign_addr_R10: assert (cfg_clear_i || hit || (clr_mask_o == '0));
    end

endmodule

// File: rtl/alert_read_mux.sv
module alert_read_mux #(
    parameter int          NFLAG       = 4,
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'h4
) (
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [NFLAG-1:0]  flags_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int PAD_W = DATA_W - NFLAG;

    always_comb begin
        if (rd_addr_i == STATUS_ADDR) begin
            rd_data_o = {{PAD_W{1'b0}}, flags_i};
        end else begin
            rd_data_o = '0;
        end
    end

    always_comb begin
        assert_upper_zero_R3: assert (rd_data_o[DATA_W-1:NFLAG] == '0);
    end

endmodule

// File: rtl/limit_alert_reg.sv
module limit_alert_reg #(
    parameter int          NCH         = 2,
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    viol_lo_i,
    input  logic [NCH-1:0]    viol_hi_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              cfg_clear_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              alert_o
);

    localparam int NFLAG = 2 * NCH;

    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] clr_mask;
    logic [NFLAG-1:0] flags;

    alert_clear_decode #(
        .NFLAG(NFLAG), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR)
    ) u_clear (
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .cfg_clear_i(cfg_clear_i),
        .clr_mask_o (clr_mask)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        always_comb begin
            set_vec[2*ch]   = viol_lo_i[ch];
            set_vec[2*ch+1] = viol_hi_i[ch];
        end

        alert_flag_cell u_lo (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[2*ch]),
            .clr_i (clr_mask[2*ch]),
            .flag_o(flags[2*ch])
        );

        alert_flag_cell u_hi (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[2*ch+1]),
            .clr_i (clr_mask[2*ch+1]),
            .flag_o(flags[2*ch+1])
        );
    end

    alert_read_mux #(
        .NFLAG(NFLAG), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR)
    ) u_read (
        .rd_addr_i(rd_addr_i),
        .flags_i  (flags),
        .rd_data_o(rd_data_o)
    );

    always_comb begin
        alert_o = |flags;
    end

    assert_alert_follows_viol_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|viol_lo_i) || (|viol_hi_i)) |=> alert_o);

    assert_cfg_quiets_alert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clear_i && !(|viol_lo_i) && !(|viol_hi_i)) |=> !alert_o);

    assert_all_ones_quiets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == STATUS_ADDR && wr_data_i == {DATA_W{1'b1}}
         && !(|viol_lo_i) && !(|viol_hi_i)) |=> (flags == '0));

endmodule

// File: tb/test_limit_alert_reg.sv
`timescale 1ns/1ps
module test_limit_alert_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] viol_lo = '0;
    logic [1:0] viol_hi = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = 4'h4;
    logic [7:0] wr_data = '0;
    logic       cfg_clr = 1'b0;
    logic [3:0] rd_addr = 4'h4;
    logic [7:0] rd_data;
    logic       alert;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    limit_alert_reg i_limit_alert_reg (
        .clk(clk), .rst_n(rst_n),
        .viol_lo_i(viol_lo), .viol_hi_i(viol_hi),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .cfg_clear_i(cfg_clr), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .alert_o(alert)
    );

    // {lo[1:0], hi[1:0], wr, data[7:0], cfg, expected flags[3:0]}
    localparam int NV = 17;
    localparam logic [17:0] VEC [NV] = '{
        {2'b01, 2'b00, 1'b0, 8'h00, 1'b0, 4'b0001}, // R2 ch1 lo
        {2'b00, 2'b10, 1'b0, 8'h00, 1'b0, 4'b1001}, // R2 R4 ch2 hi
        {2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 4'b1001}, // R4 hold
        {2'b00, 2'b00, 1'b1, 8'h01, 1'b0, 4'b1000}, // R5 clear bit0
        {2'b10, 2'b00, 1'b0, 8'h00, 1'b0, 4'b1100}, // R2 ch2 lo
        {2'b00, 2'b00, 1'b1, 8'h08, 1'b0, 4'b0100}, // R5 clear bit3
        {2'b00, 2'b01, 1'b1, 8'h04, 1'b0, 4'b0010}, // R2 R5 ch1 hi + clear bit2
        {2'b11, 2'b11, 1'b0, 8'h00, 1'b0, 4'b1111}, // R4 all
        {2'b00, 2'b00, 1'b1, 8'hFF, 1'b0, 4'b0000}, // R6
        {2'b11, 2'b00, 1'b0, 8'h00, 1'b0, 4'b0101}, // R4
        {2'b00, 2'b00, 1'b0, 8'h00, 1'b1, 4'b0000}, // R7
        {2'b00, 2'b11, 1'b0, 8'h00, 1'b1, 4'b1010}, // R8 vs cfg
        {2'b00, 2'b00, 1'b1, 8'h00, 1'b0, 4'b1010}, // R10 zero write
        {2'b00, 2'b01, 1'b1, 8'h02, 1'b0, 4'b1010}, // R8 vs bit clear
        {2'b00, 2'b00, 1'b1, 8'h0A, 1'b0, 4'b0000}, // R5 two bits
        {2'b01, 2'b00, 1'b1, 8'hFF, 1'b0, 4'b0001}, // R8 vs all ones
        {2'b00, 2'b00, 1'b1, 8'hF0, 1'b0, 4'b0001}  // R10 upper nibble only
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        viol_lo = '0; viol_hi = '0; wr_en = 1'b0; wr_data = '0;
        cfg_clr = 1'b0; wr_addr = 4'h4;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check8("R1 reset read", rd_data, 8'h00);
        check8("R1 reset alert", {7'b0, alert}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R1 after release", rd_data, 8'h00);

        for (int i = 0; i < NV; i++) begin
            viol_lo = VEC[i][17:16];
            viol_hi = VEC[i][15:14];
            wr_en   = VEC[i][13];
            wr_data = VEC[i][12:5];
            cfg_clr = VEC[i][4];
            step();
            check8($sformatf("R2 R4 R5 R6 R7 R8 R10 vector %0d", i), rd_data, {4'b0, VEC[i][3:0]});
            check8($sformatf("R3 upper bits vector %0d", i), {4'b0, rd_data[7:4]}, 8'h00);
            check8($sformatf("R9 alert vector %0d", i), {7'b0, alert}, {7'b0, |VEC[i][3:0]});
        end

        // flags now 0001; set all then write to a foreign address
        viol_lo = 2'b11; viol_hi = 2'b11;
        step();
        check8("R4 fill", rd_data, 8'h0F);
        wr_en = 1'b1; wr_addr = 4'h3; wr_data = 8'hFF;
        step();
        check8("R10 foreign address write", rd_data, 8'h0F);
        rd_addr = 4'h5;
        #1;
        check8("R11 foreign read", rd_data, 8'h00);
        rd_addr = 4'h4;
        #1;
        check8("R4 serviced flag stays", rd_data, 8'h0F);
        step();
        check8("R4 read again", rd_data, 8'h0F);

        rst_n = 1'b0;
        #1;
        check8("R1 async reset", rd_data, 8'h00);
        check8("R1 async reset alert", {7'b0, alert}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule